// File: doc/BRIEF.md
# Legacy SMRAM Decode Controller

This block steers every memory access that touches the legacy system-management memory window, the 128 KiB region from 0xA0000 through 0xBFFFF. For each access it raises one flag: high sends the access to DRAM, low sends it to the system bus. The decision combines three things: whether the address falls inside the window, whether the CPU is currently in system-management mode, and a software-visible open bit held in a small configuration register.

Firmware programs the configuration register through a simple write/read port. In that register an open bit exposes the window's DRAM to code running outside system-management mode. A lock bit freezes the whole configuration until the next reset. Setting the lock always clears the open bit, so a locked window can never remain exposed. Addresses outside the window always route to DRAM, so the block can sit on the main access path without disturbing other traffic.

Top module: `smram_decode`

## Requirements
- R1: The window is inclusive at both ends. With default parameters, addresses 0xA0000 and 0xBFFFF are inside it, and 0x9FFFF and 0xC0000 are outside it. Every address bit takes part in the compare, so an address that differs from the window only in bits above bit 19 (for example 0x1A0000) is outside.
- R2: An in-window access with `acc_smm`=1 routes to DRAM (`route_dram`=1), whatever the open bit is.
- R3: An in-window access with `acc_smm`=0 routes to the system bus (`route_dram`=0) while the open bit is 0.
- R4: An in-window access with `acc_smm`=0 routes to DRAM while the open bit is 1.
- R5: An access outside the window routes to DRAM whatever `acc_smm` and the configuration hold.
- R6: After reset both the open bit and the lock bit are 0. `cfg_rd_data` reads 0, and non-SMM in-window accesses go to the bus.
- R7: While the configuration is unlocked, a write with `cfg_wr_en`=1 loads the open bit from data bit 6 and the lock bit from data bit 4. `cfg_rd_data` returns these two bits in the same positions, and every other bit reads 0.
- R8: A write that sets the lock bit stores the open bit as 0, even when the same write has bit 6 set.
- R9: Once the lock bit is 1, configuration writes have no effect on either bit. Only reset clears the lock.
- R10: `route_dram` follows address and mode changes in the same cycle, with no register in between. A configuration write changes routing only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | CFG_W (8) | Configuration write data: bit 6 open, bit 4 lock |
| cfg_rd_data | output | CFG_W (8) | Current configuration: bit 6 open, bit 4 lock, all other bits 0 |
| acc_addr | input | ADDR_W (32) | Address of the current access |
| acc_smm | input | 1 | High when the access is made in system-management mode |
| route_dram | output | 1 | 1 routes the access to DRAM, 0 routes it to the system bus |

## Verification
The bench builds the block with a 24-bit address and leaves the window base, window size and register layout at their defaults. The narrower address still leaves four bits above the 20-bit window range. This makes an alias such as 0x1A0000 reachable, and that address would wrongly match if the compare ignored the upper bits. The 24-bit width also keeps the all-ones address a short constant that lies outside the window. The directed part of the bench covers these cases:
- a reset in the middle of the run, which shows that only reset releases the lock;
- same-cycle address changes, which show that the routing path holds no register;
- the sample taken before the capturing clock edge of a configuration write, which shows that the new configuration is not visible until that edge.

// File: rtl/smram_pkg.sv
package smram_pkg;

  // Stored decode configuration
  typedef struct packed {
    logic open;
    logic lock;
  } smram_cfg_t;

  localparam int unsigned CFG_FIELDS = 2;

endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
  import smram_pkg::*;
#(
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned OPEN_BIT = 6,
  parameter int unsigned LOCK_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output smram_cfg_t       cfg
);

  smram_cfg_t cfg_q;
  smram_cfg_t cfg_d;
  logic       upd_en;

  // Writes only land while unlocked; lock forces open low
  assign upd_en = wr_en & ~cfg_q.lock;

  always_comb begin
    cfg_d      = cfg_q;
    cfg_d.lock = wr_data[LOCK_BIT];
    cfg_d.open = wr_data[OPEN_BIT] & ~wr_data[LOCK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (upd_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  // Read-back: only the two defined fields, zeros elsewhere
  for (genvar b = 0; b < CFG_W; b++) begin : g_rd
    if (b == OPEN_BIT) begin : g_open
      assign rd_data[b] = cfg_q.open;
    end else if (b == LOCK_BIT) begin : g_lock
      assign rd_data[b] = cfg_q.lock;
    end else begin : g_zero
      assign rd_data[b] = 1'b0;
    end
  end

  // R9: once locked, the configuration never changes
  a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> $stable(cfg_q));

  // R8: the cycle the lock appears, open is already clear
  a_r8_lock_clears_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q.lock) |-> !cfg_q.open);

  // R7: nothing moves without a write strobe
  a_r7_no_spurious_update: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/smram_window_cmp.sv
module smram_window_cmp #(
  parameter int unsigned ADDR_W   = 32,
  parameter longint unsigned WIN_BASE = 64'h000A_0000,
  parameter longint unsigned WIN_SIZE = 64'h0002_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);

  localparam longint unsigned WIN_LAST = WIN_BASE + WIN_SIZE - 1;
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_LAST);

  logic ge_lo;
  logic le_hi;

  assign ge_lo  = (addr >= LO);
  assign le_hi  = (addr <= HI);
  assign in_win = ge_lo & le_hi;

endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_win,
  input  logic       smm,
  input  smram_cfg_t cfg,
  output logic       route_dram
);

  logic non_smm_ok;

  // Non-SMM access reaches DRAM only while the window is open
  assign non_smm_ok = cfg.open;
  assign route_dram = ~in_win | smm | non_smm_ok;

  // R2: system-management accesses always reach DRAM
  a_r2_smm_to_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && smm) |-> route_dram);

  // R3: closed window sends normal-mode accesses to the bus
  a_r3_closed_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !smm && !cfg.open) |-> !route_dram);

  // R4: open window lets normal-mode accesses reach DRAM
  a_r4_open_to_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && cfg.open) |-> route_dram);

endmodule

// File: rtl/smram_decode.sv
module smram_decode
  import smram_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 32,
  parameter int unsigned     CFG_W    = 8,
  parameter int unsigned     OPEN_BIT = 6,
  parameter int unsigned     LOCK_BIT = 4,
  parameter longint unsigned WIN_BASE = 64'h000A_0000,
  parameter longint unsigned WIN_SIZE = 64'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_rd_data,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  output logic              route_dram
);

  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + WIN_SIZE - 1);

  smram_cfg_t cfg;
  logic       in_win;

  smram_cfg_reg #(
    .CFG_W    (CFG_W),
    .OPEN_BIT (OPEN_BIT),
    .LOCK_BIT (LOCK_BIT)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .cfg     (cfg)
  );

  smram_window_cmp #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_cmp (
    .addr   (acc_addr),
    .in_win (in_win)
  );

  smram_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_win     (in_win),
    .smm        (acc_smm),
    .cfg        (cfg),
    .route_dram (route_dram)
  );

  // R5: addresses outside the window always go to DRAM
  a_r5_outside_dram: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_addr < WIN_LO) || (acc_addr > WIN_HI)) |-> route_dram);

  // R9: a locked register never reports the window open
  a_r9_locked_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[LOCK_BIT] |-> !cfg_rd_data[OPEN_BIT]);

endmodule

// File: tb/smram_decode_test.sv
module smram_decode_test;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 24;
  localparam int unsigned CW = 8;
  localparam int unsigned NVEC = 12;

  // {addr, smm, open, expected route_dram, requirement number}
  typedef struct packed {
    logic [AW-1:0] addr;
    logic          smm;
    logic          open;
    logic          exp;
    logic [7:0]    req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{24'h09FFFF, 1'b0, 1'b0, 1'b1, 8'd1},  // R1 just below
    '{24'h0A0000, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 first byte
    '{24'h0BFFFF, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 last byte
    '{24'h0C0000, 1'b0, 1'b0, 1'b1, 8'd1},  // R1 just above
    '{24'h1A0000, 1'b0, 1'b0, 1'b1, 8'd1},  // R1 upper-bit alias
    '{24'h0B1234, 1'b1, 1'b0, 1'b1, 8'd2},  // R2 smm, closed
    '{24'h0A8000, 1'b1, 1'b1, 1'b1, 8'd2},  // R2 smm, open
    '{24'h0A0001, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 closed
    '{24'h0A8000, 1'b0, 1'b1, 1'b1, 8'd4},  // R4 open
    '{24'h0BFFFF, 1'b0, 1'b1, 1'b1, 8'd4},  // R4 open, last byte
    '{24'h000000, 1'b0, 1'b0, 1'b1, 8'd5},  // R5 low memory
    '{24'hFFFFFF, 1'b1, 1'b0, 1'b1, 8'd5}   // R5 top of space
  };

  logic          clk;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [CW-1:0] cfg_wr_data;
  logic [CW-1:0] cfg_rd_data;
  logic [AW-1:0] acc_addr;
  logic          acc_smm;
  logic          route_dram;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  smram_decode #(.ADDR_W(AW), .CFG_W(CW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .acc_addr    (acc_addr),
    .acc_smm     (acc_smm),
    .route_dram  (route_dram)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [CW-1:0] d);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    cfg_wr_data = '0;
  endtask

  task automatic access(input logic [AW-1:0] a, input logic s);
    acc_addr = a;
    acc_smm  = s;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n       = 1'b0;
    cfg_wr_en   = 1'b0;
    cfg_wr_data = '0;
    acc_addr    = '0;
    acc_smm     = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: reset state
    check("R6", 32'(cfg_rd_data), 32'h00);
    access(24'h0A0000, 1'b0);
    check("R6", 32'(route_dram), 32'd0);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      cfg_write({1'b0, VECS[i].open, 6'b0});
      access(VECS[i].addr, VECS[i].smm);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), 32'(route_dram), 32'(VECS[i].exp));
    end

    // R7: field positions and read-back
    cfg_write(8'hAF);               // bit 6 clear, bit 4 clear, junk elsewhere
    check("R7", 32'(cfg_rd_data), 32'h00);
    cfg_write(8'hC0);               // open set
    check("R7", 32'(cfg_rd_data), 32'h40);

    // R10: same-cycle address response, config only after edge
    access(24'h0B0000, 1'b0);
    check("R10", 32'(route_dram), 32'd1);
    access(24'h0D0000, 1'b0);
    check("R10", 32'(route_dram), 32'd1);
    access(24'h0B0000, 1'b0);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = 8'h00;
    #1;
    check("R10 before edge", 32'(route_dram), 32'd1);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
    check("R10 after edge", 32'(route_dram), 32'd0);

    // R8: lock with open set in the same write
    cfg_write(8'h50);
    check("R8", 32'(cfg_rd_data), 32'h10);
    access(24'h0A4000, 1'b0);
    check("R8", 32'(route_dram), 32'd0);

    // R9: writes ignored while locked
    cfg_write(8'h40);
    check("R9", 32'(cfg_rd_data), 32'h10);
    access(24'h0A4000, 1'b0);
    check("R9", 32'(route_dram), 32'd0);
    cfg_write(8'h00);
    check("R9", 32'(cfg_rd_data), 32'h10);

    // R8: lock after open already set clears open
    do_reset();
    check("R9 reset clears lock", 32'(cfg_rd_data), 32'h00);
    cfg_write(8'h40);
    check("R7", 32'(cfg_rd_data), 32'h40);
    cfg_write(8'h10);
    check("R8", 32'(cfg_rd_data), 32'h10);
    access(24'h0BFFFF, 1'b0);
    check("R8", 32'(route_dram), 32'd0);
    access(24'h0BFFFF, 1'b1);
    check("R2 locked", 32'(route_dram), 32'd1);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule